// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block is the control state machine that takes a programmable logic device from power-on to its operational state. It waits for a valid supply and a passing self-test of a sample pair of configuration cells. It then runs one power-on time-out and wipes the configuration store one frame per cycle. Next it negotiates release of a shared open-drain ready line with the other devices on the chain, wipes the store once more, and latches the mode pins. It then accepts data frames from the loader until the declared length is reached, runs a start-up interval, and settles in the operational state.

A low level on the reprogram pin restarts the flow at the wipe stage from any point past the power-on wait, and no time-out is run. If the loader flags a bad frame, the block pulls the shared ready line low and halts until the next reprogram request. All intervals are parameters counted in clock cycles. Bit 0 of the mode pins selects the role: 0 means the device drives the configuration clock (master) and 1 means it receives the clock (slave).

Top module: `cfg_seq_top`

## Requirements
- R1: While rst_ni is low, state_o reads 0 (power wait), init_low_o is 1, and clr_en_o, cclk_en_o, done_o and mode_o are 0. State codes: 0 power wait, 1 time-out, 2 wipe, 3 ready wait, 4 final wipe, 5 master delay, 6 load, 7 start-up, 8 operational, 9 error.
- R2: The block stays in code 0 until supply_ok_i and selftest_ok_i are high in the same cycle. prog_ni is ignored in code 0.
- R3: The time-out (code 1) lasts POR_CYC cycles when mode_i[0] is 1 and 4*POR_CYC cycles when mode_i[0] is 0, with mode_i[0] taken in the cycle that leaves code 0. Code 1 is entered only from code 0.
- R4: In code 2 one frame is wiped per cycle, with clr_addr_o running from 0 to NUM_FRAMES-1 and wrapping. The block leaves code 2 only at address NUM_FRAMES-1 with prog_ni high, so a P-cycle reprogram pulse (P>=1) gives NUM_FRAMES*ceil(P/NUM_FRAMES) wipe cycles.
- R5: init_low_o is 1 in codes 0, 1, 2 and 9 and 0 in every other code. In code 3 wiping continues until init_i reads high, so code 3 lasts one cycle more than init_i is held low by another device.
- R6: The final wipe (code 4) restarts at address 0 and lasts exactly NUM_FRAMES cycles.
- R7: After the final wipe, a master (mode_i[0]=0) spends MWAIT_CYC cycles in code 5 and a slave goes straight to code 6. mode_i is latched into mode_o at the clock edge that enters code 6.
- R8: In code 6 a frame is counted in each cycle with frame_done_i high. The cycle that counts frame number len_i (len_i>=1) moves to code 7. cclk_en_o is 1 in codes 6 and 7 when the latched mode_o[0] is 0, and 0 otherwise.
- R9: frame_err_i high in code 6 moves to code 9, and this wins over completion on the same frame. Code 9 holds while prog_ni stays high. frame_err_i has no effect in any other code.
- R10: Code 7 lasts STARTUP_CYC cycles, then code 8 is held with done_o at 1.
- R11: prog_ni low in any code other than 0 and 2 moves to code 2 at the next edge, restarting at address 0. This wins over every other transition, and code 1 is not visited again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| supply_ok_i | input | 1 | Supply has reached operating level |
| selftest_ok_i | input | 1 | Sample configuration cell pair passed write/read test |
| prog_ni | input | 1 | Reprogram request, active low |
| mode_i | input | MODE_W | Mode pins; bit 0 low selects master |
| init_i | input | 1 | Sensed level of the shared open-drain ready line |
| frame_done_i | input | 1 | Loader finished one data frame this cycle |
| frame_err_i | input | 1 | Loader reports a bad frame |
| len_i | input | LEN_W | Declared number of data frames |
| init_low_o | output | 1 | Pull the shared ready line low |
| clr_en_o | output | 1 | A frame is wiped this cycle |
| clr_addr_o | output | ADDR_W | Frame being wiped |
| cclk_en_o | output | 1 | Drive the configuration clock |
| done_o | output | 1 | Device is operational |
| mode_o | output | MODE_W | Latched mode pins |
| state_o | output | 4 | Current state code |

## Verification
There are two same-cycle collisions. The first is a frame error on the final frame, where the error must beat completion and the block must land in code 9, not code 7. The second is a reprogram pulse in the same cycle as a frame error, where the restart must win, the error state must never be visited, and the next pass must complete normally. The bench provokes both from a monitor that raises frame_err_i, and optionally pulls prog_ni low, exactly on a chosen frame index. It judges the outcome from the per-state cycle counts it collects at the ports. Sweeps over role, length, frame gaps, ready-line hold and reprogram pulse width are checked against arithmetic expectations.

// File: rtl/cfg_seq_pkg.sv
package cfg_seq_pkg;
  typedef enum logic [3:0] {
    ST_PWR_WAIT  = 4'd0,
    ST_TIMEOUT   = 4'd1,
    ST_WIPE      = 4'd2,
    ST_RDY_WAIT  = 4'd3,
    ST_WIPE_LAST = 4'd4,
    ST_MST_DLY   = 4'd5,
    ST_LOAD      = 4'd6,
    ST_STARTUP   = 4'd7,
    ST_OPER      = 4'd8,
    ST_ERROR     = 4'd9
  } seq_state_e;
endpackage

// File: rtl/cfg_seq_timer.sv
module cfg_seq_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

  p_timer_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/cfg_seq_scan.sv
module cfg_seq_scan #(
  parameter int NF = 8,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);
  logic [AW-1:0] addr_q;

  assign last_o = (addr_q == AW'(NF - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        addr_q <= '0;
    else if (restart_i) addr_q <= '0;
    else if (step_i)    addr_q <= last_o ? '0 : addr_q + AW'(1);
  end

  assign addr_o = addr_q;

  p_scan_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !restart_i && last_o) |=> (addr_q == '0));
  p_scan_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_q <= AW'(NF - 1));
endmodule

// File: rtl/cfg_seq_frames.sv
module cfg_seq_frames #(
  parameter int LW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [LW-1:0] len_i,
  output logic          hit_o
);
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + LW'(1);
  end

  // widened compare: frame number len_i reached on this increment
  assign hit_o = inc_i && (({1'b0, cnt_q} + (LW+1)'(1)) == {1'b0, len_i});

  p_cnt_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/cfg_seq_top.sv
module cfg_seq_top
  import cfg_seq_pkg::*;
#(
  parameter int POR_CYC     = 20,
  parameter int MWAIT_CYC   = 6,
  parameter int STARTUP_CYC = 4,
  parameter int NUM_FRAMES  = 8,
  parameter int LEN_W       = 8,
  parameter int MODE_W      = 3,
  localparam int ADDR_W     = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int T_A        = (4 * POR_CYC > MWAIT_CYC) ? 4 * POR_CYC : MWAIT_CYC,
  localparam int T_MAX      = (T_A > STARTUP_CYC) ? T_A : STARTUP_CYC,
  localparam int TMR_W      = $clog2(T_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              supply_ok_i,
  input  logic              selftest_ok_i,
  input  logic              prog_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              init_i,
  input  logic              frame_done_i,
  input  logic              frame_err_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              init_low_o,
  output logic              clr_en_o,
  output logic [ADDR_W-1:0] clr_addr_o,
  output logic              cclk_en_o,
  output logic              done_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [3:0]        state_o
);
  seq_state_e state_q, state_d;
  logic [MODE_W-1:0] mode_q;

  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              scan_restart, scan_step, scan_last;
  logic              cnt_clr, cnt_inc, cnt_hit;
  logic              mode_latch;

  cfg_seq_timer #(.W(TMR_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  cfg_seq_scan #(.NF(NUM_FRAMES), .AW(ADDR_W)) u_scan (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (scan_restart),
    .step_i    (scan_step),
    .addr_o    (clr_addr_o),
    .last_o    (scan_last)
  );

  cfg_seq_frames #(.LW(LEN_W)) u_frames (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cnt_clr),
    .inc_i  (cnt_inc),
    .len_i  (len_i),
    .hit_o  (cnt_hit)
  );

  always_comb begin
    state_d      = state_q;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    scan_restart = 1'b0;
    scan_step    = 1'b0;
    cnt_clr      = 1'b0;
    cnt_inc      = 1'b0;
    mode_latch   = 1'b0;
    unique case (state_q)
      ST_PWR_WAIT: begin
        if (supply_ok_i && selftest_ok_i) begin
          state_d  = ST_TIMEOUT;
          tmr_load = 1'b1;
          tmr_val  = mode_i[0] ? TMR_W'(POR_CYC) : TMR_W'(4 * POR_CYC);
        end
      end
      ST_TIMEOUT: begin
        if (tmr_zero) begin
          state_d      = ST_WIPE;
          scan_restart = 1'b1;
        end
      end
      ST_WIPE: begin
        scan_step = 1'b1;
        if (prog_ni && scan_last) state_d = ST_RDY_WAIT;
      end
      ST_RDY_WAIT: begin
        scan_step = 1'b1;
        if (init_i) begin
          state_d      = ST_WIPE_LAST;
          scan_restart = 1'b1;
        end
      end
      ST_WIPE_LAST: begin
        scan_step = 1'b1;
        if (scan_last) begin
          if (!mode_i[0]) begin
            state_d  = ST_MST_DLY;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(MWAIT_CYC);
          end else begin
            state_d    = ST_LOAD;
            mode_latch = 1'b1;
            cnt_clr    = 1'b1;
          end
        end
      end
      ST_MST_DLY: begin
        if (tmr_zero) begin
          state_d    = ST_LOAD;
          mode_latch = 1'b1;
          cnt_clr    = 1'b1;
        end
      end
      ST_LOAD: begin
        if (frame_err_i) begin
          state_d = ST_ERROR;
        end else if (frame_done_i) begin
          cnt_inc = 1'b1;
          if (cnt_hit) begin
            state_d  = ST_STARTUP;
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(STARTUP_CYC);
          end
        end
      end
      ST_STARTUP: if (tmr_zero) state_d = ST_OPER;
      ST_OPER:    state_d = ST_OPER;
      ST_ERROR:   state_d = ST_ERROR;
      default:    state_d = ST_PWR_WAIT;
    endcase

    // reprogram request overrides everything past the power wait
    if (!prog_ni && state_q != ST_PWR_WAIT && state_q != ST_WIPE) begin
      state_d      = ST_WIPE;
      scan_restart = 1'b1;
      tmr_load     = 1'b0;
      mode_latch   = 1'b0;
      cnt_inc      = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR_WAIT;
      mode_q  <= '0;
    end else begin
      state_q <= state_d;
      if (mode_latch) mode_q <= mode_i;
    end
  end

  assign init_low_o = (state_q == ST_PWR_WAIT) || (state_q == ST_TIMEOUT) ||
                      (state_q == ST_WIPE)     || (state_q == ST_ERROR);
  assign clr_en_o   = (state_q == ST_WIPE) || (state_q == ST_RDY_WAIT) ||
                      (state_q == ST_WIPE_LAST);
  assign cclk_en_o  = !mode_q[0] && ((state_q == ST_LOAD) || (state_q == ST_STARTUP));
  assign done_o     = (state_q == ST_OPER);
  assign mode_o     = mode_q;
  assign state_o    = state_q;

  p_pwr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PWR_WAIT && !(supply_ok_i && selftest_ok_i)) |=> state_q == ST_PWR_WAIT);
  p_timeout_entry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TIMEOUT) |->
      ($past(state_q) == ST_PWR_WAIT || $past(state_q) == ST_TIMEOUT));
  p_last_wipe_start_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WIPE_LAST && $past(state_q) != ST_WIPE_LAST) |-> clr_addr_o == '0);
  p_load_entry_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && $past(state_q) != ST_LOAD) |->
      ($past(state_q) == ST_WIPE_LAST || $past(state_q) == ST_MST_DLY));
  p_err_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR && prog_ni) |=> state_q == ST_ERROR);
  p_err_pulls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERROR) |-> init_low_o);
  p_prog_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!prog_ni && state_q != ST_PWR_WAIT) |=> state_q == ST_WIPE);
endmodule

// File: tb/tb_cfg_seq_top.sv
module tb_cfg_seq_top;
  localparam int POR = 20;
  localparam int MW  = 6;
  localparam int SU  = 4;
  localparam int NF  = 8;
  localparam int AW  = 3;

  localparam int S_PWR = 0, S_TMO = 1, S_WIPE = 2, S_RDY = 3, S_LAST = 4;
  localparam int S_MDLY = 5, S_LOAD = 6, S_SU = 7, S_OPER = 8, S_ERR = 9;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_ni, supply_ok, selftest_ok, prog_task, prog_mon_low;
  logic [2:0]    mode;
  logic          ext_low, frame_done, frame_err;
  logic [7:0]    len;
  logic          init_low, clr_en, cclk_en, done;
  logic [AW-1:0] clr_addr;
  logic [2:0]    mode_lat;
  logic [3:0]    state;
  logic          init_line, prog_n;

  assign init_line = !init_low && !ext_low;
  assign prog_n    = prog_task && !prog_mon_low;

  cfg_seq_top #(.POR_CYC(POR), .MWAIT_CYC(MW), .STARTUP_CYC(SU), .NUM_FRAMES(NF),
                .LEN_W(8), .MODE_W(3)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .selftest_ok_i(selftest_ok),
    .prog_ni(prog_n), .mode_i(mode), .init_i(init_line), .frame_done_i(frame_done),
    .frame_err_i(frame_err), .len_i(len), .init_low_o(init_low), .clr_en_o(clr_en),
    .clr_addr_o(clr_addr), .cclk_en_o(cclk_en), .done_o(done), .mode_o(mode_lat),
    .state_o(state)
  );

  int checks = 0, failures = 0;
  int st_cnt[16];
  int init_bad, addr_bad, cclk_cnt, lcyc, fidx;
  bit run_on, cfg_gap, cfg_collide, cfg_errout, err_fired;
  int cfg_hold, cfg_err_at;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pulls_low(int s);
    return s == S_PWR || s == S_TMO || s == S_WIPE || s == S_ERR;
  endfunction

  task automatic clear_counts();
    for (int i = 0; i < 16; i++) st_cnt[i] = 0;
    init_bad = 0; addr_bad = 0; cclk_cnt = 0;
  endtask

  // monitor and loader model, acting on falling edges
  always @(negedge clk) begin
    if (run_on) begin
      st_cnt[state]++;
      if (init_low != pulls_low(int'(state))) init_bad++;
      if (state == S_WIPE && int'(clr_addr) != (st_cnt[S_WIPE] - 1) % NF) addr_bad++;
      if (state == S_LAST && int'(clr_addr) != (st_cnt[S_LAST] - 1) % NF) addr_bad++;
      if (cclk_en) cclk_cnt++;
      if (state == S_MDLY) mode[2:1] = st_cnt[S_MDLY][1:0];
      if (state == S_RDY && st_cnt[S_RDY] > cfg_hold) ext_low = 1'b0;
      if (state == S_LOAD) begin
        bit dn;
        lcyc++;
        dn = cfg_gap ? lcyc[0] : 1'b1;
        if (dn) fidx++;
        frame_done = dn;
        frame_err  = dn && !err_fired && fidx == cfg_err_at;
        if (frame_err) begin
          err_fired = 1'b1;
          if (cfg_collide) prog_mon_low = 1'b1;
        end
      end else begin
        lcyc = 0; fidx = 0;
        frame_done   = 1'b0;
        frame_err    = cfg_errout;
        prog_mon_low = 1'b0;
      end
    end
  end

  task automatic wait_end();
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      if (state == S_OPER || state == S_ERR) break;
    end
  endtask

  function automatic int load_cycles(int n, bit gap);
    return gap ? 2 * n - 1 : n;
  endfunction

  task automatic do_run(bit master, int ln, bit gap, int err_at, int hold, bit collide, bit errout);
    run_on = 0; err_fired = 0; ext_low = 1; prog_mon_low = 0;
    frame_done = 0; frame_err = 0;
    cfg_gap = gap; cfg_err_at = err_at; cfg_hold = hold;
    cfg_collide = collide; cfg_errout = errout;
    rst_ni = 0; supply_ok = 0; selftest_ok = 0; prog_task = 1;
    mode = master ? 3'b110 : 3'b011; len = 8'(ln);
    repeat (2) @(posedge clk); #1;
    // R1: reset state
    chk("R1 state", int'(state), S_PWR);
    chk("R1 outputs", {init_low, clr_en, cclk_en, done, |mode_lat}, 5'b10000);
    rst_ni = 1; prog_task = 0;
    repeat (3) @(posedge clk); #1;
    chk("R2 prog ignored, no supply", int'(state), S_PWR);
    prog_task = 1; supply_ok = 1;
    repeat (2) @(posedge clk); #1;
    chk("R2 self-test pending", int'(state), S_PWR);
    clear_counts(); run_on = 1; selftest_ok = 1;
    wait_end();
    if (errout) begin
      repeat (4) @(posedge clk); #1;
    end
    chk("R3 time-out cycles", st_cnt[S_TMO], master ? 4 * POR : POR);
    chk("R4 wipe cycles", st_cnt[S_WIPE], collide ? 2 * NF : NF);
    chk("R4 wipe addresses", addr_bad, 0);
    chk("R5 ready line drive", init_bad, 0);
    if (!collide) chk("R5 ready wait cycles", st_cnt[S_RDY], hold + 1);
    chk("R6 final wipe cycles", st_cnt[S_LAST], collide ? 2 * NF : NF);
    chk("R7 master delay cycles", st_cnt[S_MDLY], (master ? MW : 0) * (collide ? 2 : 1));
    if (collide) begin
      chk("R11 restart beats error", st_cnt[S_ERR], 0);
      chk("R11 pass after restart", int'(state), S_OPER);
      chk("R8 load cycles twice", st_cnt[S_LOAD], err_at + ln);
    end else if (err_at != 0) begin
      chk("R9 load cycles to error", st_cnt[S_LOAD], load_cycles(err_at, gap));
      chk("R9 error state", int'(state), S_ERR);
      repeat (5) @(posedge clk); #1;
      chk("R9 error holds", int'(state), S_ERR);
      chk("R9 line pulled", {init_low, done}, 2'b10);
      // recover with a one-cycle reprogram pulse
      clear_counts();
      prog_task = 0; @(posedge clk); #1; prog_task = 1;
      wait_end();
      chk("R11 recovery skips time-out", st_cnt[S_TMO], 0);
      chk("R11 recovery wipe", st_cnt[S_WIPE], NF);
      chk("R11 recovery done", int'(state), S_OPER);
    end else begin
      chk("R8 load cycles", st_cnt[S_LOAD], load_cycles(ln, gap));
      chk("R8 clock enable cycles", cclk_cnt, master ? load_cycles(ln, gap) + SU : 0);
      chk("R10 start-up cycles", st_cnt[S_SU], SU);
      chk("R10 operational", {int'(state), int'(done)}, {S_OPER, 1});
      chk("R7 latched mode", int'(mode_lat), master ? {MW[1:0], 1'b0} : 3'b011);
      if (errout) chk("R9 error ignored outside load", st_cnt[S_ERR], 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_on = 0; ext_low = 1; prog_mon_low = 0; frame_done = 0; frame_err = 0;
    rst_ni = 0; supply_ok = 0; selftest_ok = 0; prog_task = 1; mode = 3'b011; len = 8'd1;
    // sweep role x length x frame gaps x ready-line hold
    for (int m = 0; m < 2; m++)
      for (int l = 1; l <= 3; l += 2)
        for (int g = 0; g < 2; g++)
          for (int h = 0; h <= 2; h += 2)
            do_run(m[0], l, g[0], 0, h, 1'b0, 1'b0);
    // errors on every frame position, including the final one (R9 over R8)
    for (int m = 0; m < 2; m++)
      for (int e = 1; e <= 3; e++)
        do_run(m[0], 3, e[0] ^ m[0], e, 1, 1'b0, 1'b0);
    // error asserted outside the load state
    do_run(1'b0, 2, 1'b0, 0, 0, 1'b0, 1'b1);
    // reprogram in the same cycle as a frame error (R11 over R9)
    do_run(1'b1, 3, 1'b0, 2, 0, 1'b1, 1'b0);
    // reprogram pulse width sweep from the operational state
    do_run(1'b1, 1, 1'b0, 0, 0, 1'b0, 1'b0);
    for (int p = 1; p <= 2 * NF + 1; p++) begin
      clear_counts();
      prog_task = 0;
      repeat (p) @(posedge clk);
      #1; prog_task = 1;
      wait_end();
      chk("R4 wipe length vs pulse", st_cnt[S_WIPE], NF * ((p + NF - 1) / NF));
      chk("R11 no time-out on reprogram", st_cnt[S_TMO], 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule